// File: doc/BRIEF.md
# Parallel-Translated Cache Lookup

This block is the lookup stage of a small first-level data cache whose set arrays are read in the same cycle as a fully associative translation buffer. The set is picked with bits of the virtual address that lie inside the page, so no translation is needed to start the array read. Once both the translation result and the stored tags are available, the translated physical page number is compared against the tag of every way in parallel. Capacity grows by adding ways. The number of sets is always the page size divided by the line size.

A request presents a virtual address, a read/write flag and write data. One cycle later the block reports exactly one outcome: hit, miss, translation miss or permission fault. A read hit also returns the word. A read miss raises a refill request that names the physical line and a victim way picked round-robin. An outside responder answers with a fill that installs the line. Every permitted write goes straight through to memory, and a write that hits also updates the cached word. Translation entries are loaded through a simple write port.

Top module: `vipt_lookup`

## Requirements
- R1: A request accepted at a clock edge gives `rsp_valid` high for exactly the following cycle. In that cycle exactly one of `rsp_hit`, `rsp_miss`, `rsp_tlb_miss`, `rsp_fault` is high. With no request all four are low.
- R2: The set is `va[PAGE_BITS-1:OFF_BITS]` and the stored tag is the full physical page number. A hit needs a valid line whose tag equals the translated page number. Two virtual pages mapped to one physical page therefore hit the same line.
- R3: The translation buffer has `TLB_N` fully associative entries, loaded through the `tlb_wr_*` port. If no valid entry matches `va[VA_W-1:PAGE_BITS]`, the result is a translation miss with no refill and no write-through. When several entries match, the lowest index wins.
- R4: A read whose entry has read permission clear, or a write whose entry has write permission clear, is reported as a fault. It causes no refill and no write-through.
- R5: A read hit returns the stored word of the matching way on `rsp_rdata`.
- R6: A permitted read miss raises `refill_req` in the response cycle. `refill_line` is {physical page, set} and `refill_way` is the set's round-robin pointer. The pointer starts at way 0 and advances by one, wrapping, on each read miss in that set.
- R7: A fill writes its word and tag into the given way of the set in `fill_line[IDX_W-1:0]` and marks that way valid. Any other way of the set that holds the same tag is invalidated.
- R8: A permitted write drives `wt_valid` with the physical byte address {page, set, offset} and the write data. On a hit it also replaces the word of the hit way. On a miss it neither allocates nor requests a refill.
- R9: Reset invalidates every line and every translation entry, sets all round-robin pointers to way 0 and leaves all outputs idle.
- R10: At most one way of a set matches a lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_va | input | VA_W | Virtual byte address |
| req_wdata | input | DATA_W | Write data |
| tlb_wr_en | input | 1 | Load a translation entry |
| tlb_wr_idx | input | TLB_W | Entry index to load |
| tlb_wr_vpn | input | VPN_W | Virtual page number of the entry |
| tlb_wr_ppn | input | PPN_W | Physical page number of the entry |
| tlb_wr_rd_ok | input | 1 | Entry allows reads |
| tlb_wr_wr_ok | input | 1 | Entry allows writes |
| rsp_valid | output | 1 | Response cycle |
| rsp_hit | output | 1 | Tag hit |
| rsp_miss | output | 1 | Tag miss |
| rsp_tlb_miss | output | 1 | No translation found |
| rsp_fault | output | 1 | Permission violation |
| rsp_rdata | output | DATA_W | Read data on a read hit, else zero |
| refill_req | output | 1 | Refill request for a read miss |
| refill_line | output | LINE_W | Physical line address to fetch |
| refill_way | output | WAY_W | Victim way |
| fill_valid | input | 1 | Install a line |
| fill_line | input | LINE_W | Physical line address of the fill |
| fill_way | input | WAY_W | Way to install into |
| fill_data | input | DATA_W | Line word |
| wt_valid | output | 1 | Write-through strobe |
| wt_addr | output | PA_W | Physical byte address of the write |
| wt_data | output | DATA_W | Write-through data |

## Verification
The checker watches every cycle for the one-cycle response timing, for exactly one outcome per response, and for at most one matching way. It also checks that refills come only from permitted read misses and write-through only from permitted writes, and that translation misses and faults cause neither. What the word-level results are can only be shown by the bench's scenarios. These are the returned data, the refill line and victim way sequence over many sets, eviction by round-robin, write updates, no allocation on a write miss, hits through an aliased virtual page, and invalidation of a duplicate way by a fill. The bench tracks them against its own model of tags, pointers and translations.

// File: rtl/vipt_lookup.sv
module vipt_lookup #(
  parameter int VA_W      = 16,
  parameter int PA_W      = 16,
  parameter int PAGE_BITS = 8,
  parameter int OFF_BITS  = 2,
  parameter int DATA_W    = 32,
  parameter int WAYS      = 2,
  parameter int TLB_N     = 4,
  localparam int VPN_W  = VA_W - PAGE_BITS,
  localparam int PPN_W  = PA_W - PAGE_BITS,
  localparam int IDX_W  = PAGE_BITS - OFF_BITS,
  localparam int SETS   = 1 << IDX_W,
  localparam int LINE_W = PA_W - OFF_BITS,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int TLB_W  = $clog2(TLB_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [VA_W-1:0]   req_va,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              tlb_wr_en,
  input  logic [TLB_W-1:0]  tlb_wr_idx,
  input  logic [VPN_W-1:0]  tlb_wr_vpn,
  input  logic [PPN_W-1:0]  tlb_wr_ppn,
  input  logic              tlb_wr_rd_ok,
  input  logic              tlb_wr_wr_ok,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic              rsp_tlb_miss,
  output logic              rsp_fault,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              refill_req,
  output logic [LINE_W-1:0] refill_line,
  output logic [WAY_W-1:0]  refill_way,
  input  logic              fill_valid,
  input  logic [LINE_W-1:0] fill_line,
  input  logic [WAY_W-1:0]  fill_way,
  input  logic [DATA_W-1:0] fill_data,
  output logic              wt_valid,
  output logic [PA_W-1:0]   wt_addr,
  output logic [DATA_W-1:0] wt_data
);

  // captured request
  logic                s_valid, s_write;
  logic [VPN_W-1:0]    s_vpn;
  logic [IDX_W-1:0]    s_set;
  logic [OFF_BITS-1:0] s_off;
  logic [DATA_W-1:0]   s_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) s_valid <= 1'b0;
    else        s_valid <= req_valid;
    if (req_valid) begin
      s_write <= req_write;
      s_vpn   <= req_va[VA_W-1:PAGE_BITS];
      s_set   <= req_va[PAGE_BITS-1:OFF_BITS];
      s_off   <= req_va[OFF_BITS-1:0];
      s_wdata <= req_wdata;
    end
  end

  // translation buffer
  logic [TLB_N-1:0] tv, trd, twr;
  logic [VPN_W-1:0] tvpn [TLB_N];
  logic [PPN_W-1:0] tppn [TLB_N];

  always_ff @(posedge clk) begin
    if (!rst_n) tv <= '0;
    else if (tlb_wr_en) tv[tlb_wr_idx] <= 1'b1;
    if (tlb_wr_en) begin
      trd[tlb_wr_idx]  <= tlb_wr_rd_ok;
      twr[tlb_wr_idx]  <= tlb_wr_wr_ok;
      tvpn[tlb_wr_idx] <= tlb_wr_vpn;
      tppn[tlb_wr_idx] <= tlb_wr_ppn;
    end
  end

  logic             t_hit, t_rd, t_wr;
  logic [PPN_W-1:0] t_ppn;

  always_comb begin
    t_hit = 1'b0; t_rd = 1'b0; t_wr = 1'b0; t_ppn = '0;
    for (int i = TLB_N - 1; i >= 0; i--)
      if (tv[i] && tvpn[i] == s_vpn) begin
        t_hit = 1'b1; t_rd = trd[i]; t_wr = twr[i]; t_ppn = tppn[i];
      end
  end

  // set arrays, read in the same cycle as the translation
  logic [PPN_W-1:0]  tag_q [SETS][WAYS];
  logic [DATA_W-1:0] dat_q [SETS][WAYS];
  logic [WAYS-1:0]   vld_q [SETS];
  logic [WAY_W-1:0]  rr_q  [SETS];

  logic [WAYS-1:0] way_match;
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign way_match[w] = t_hit && vld_q[s_set][w] && (tag_q[s_set][w] == t_ppn);
  end

  logic [WAY_W-1:0]  hit_way;
  logic [DATA_W-1:0] hit_data;
  always_comb begin
    hit_way = '0; hit_data = '0;
    for (int w = 0; w < WAYS; w++)
      if (way_match[w]) begin
        hit_way  = WAY_W'(w);
        hit_data = dat_q[s_set][w];
      end
  end

  logic perm_ok, go, tag_hit;
  assign perm_ok = s_write ? t_wr : t_rd;
  assign go      = s_valid && t_hit && perm_ok;
  assign tag_hit = |way_match;

  assign rsp_valid    = s_valid;
  assign rsp_tlb_miss = s_valid && !t_hit;
  assign rsp_fault    = s_valid && t_hit && !perm_ok;
  assign rsp_hit      = go && tag_hit;
  assign rsp_miss     = go && !tag_hit;
  assign rsp_rdata    = (rsp_hit && !s_write) ? hit_data : '0;

  assign refill_req  = rsp_miss && !s_write;
  assign refill_line = {t_ppn, s_set};
  assign refill_way  = rr_q[s_set];

  assign wt_valid = go && s_write;
  assign wt_addr  = {t_ppn, s_set, s_off};
  assign wt_data  = s_wdata;

  logic [IDX_W-1:0] f_set;
  logic [PPN_W-1:0] f_tag;
  assign f_set = fill_line[IDX_W-1:0];
  assign f_tag = fill_line[LINE_W-1:IDX_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        rr_q[s]  <= '0;
      end
    end else begin
      if (refill_req)
        rr_q[s_set] <= (rr_q[s_set] == WAY_W'(WAYS - 1)) ? '0 : rr_q[s_set] + WAY_W'(1);
      if (fill_valid)
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == fill_way) vld_q[f_set][w] <= 1'b1;
          else if (tag_q[f_set][w] == f_tag) vld_q[f_set][w] <= 1'b0;
        end
    end
  end

  always_ff @(posedge clk) begin
    if (rsp_hit && s_write) dat_q[s_set][hit_way] <= s_wdata;
    if (fill_valid) begin
      tag_q[f_set][fill_way] <= f_tag;
      dat_q[f_set][fill_way] <= fill_data;
    end
  end

endmodule

module vipt_lookup_chk #(
  parameter int WAYS = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            s_write,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic            rsp_miss,
  input logic            rsp_tlb_miss,
  input logic            rsp_fault,
  input logic            refill_req,
  input logic            wt_valid,
  input logic [WAYS-1:0] way_match
);

  assert_resp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_resp_needs_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid));

  assert_one_outcome_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_tlb_miss, rsp_fault}) == 1);

  assert_idle_outcome_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_tlb_miss, rsp_fault}) == 0);

  assert_tlb_miss_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_tlb_miss |-> !refill_req && !wt_valid);

  assert_fault_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> !refill_req && !wt_valid);

  assert_refill_read_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
    refill_req |-> rsp_miss && !s_write);

  assert_write_through_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wt_valid |-> s_write && (rsp_hit || rsp_miss));

  assert_single_way_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_match));

endmodule

bind vipt_lookup vipt_lookup_chk #(.WAYS(WAYS)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .s_write(s_write),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
  .rsp_tlb_miss(rsp_tlb_miss), .rsp_fault(rsp_fault),
  .refill_req(refill_req), .wt_valid(wt_valid), .way_match(way_match)
);

// File: tb/vipt_lookup_tb_top.sv
module vipt_lookup_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 0, req_write = 0;
  logic [15:0] req_va = 0;
  logic [31:0] req_wdata = 0;
  logic        tlb_wr_en = 0;
  logic [1:0]  tlb_wr_idx = 0;
  logic [7:0]  tlb_wr_vpn = 0, tlb_wr_ppn = 0;
  logic        tlb_wr_rd_ok = 0, tlb_wr_wr_ok = 0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_tlb_miss, rsp_fault;
  logic [31:0] rsp_rdata;
  logic        refill_req;
  logic [13:0] refill_line;
  logic [0:0]  refill_way;
  logic        fill_valid = 0;
  logic [13:0] fill_line = 0;
  logic [0:0]  fill_way = 0;
  logic [31:0] fill_data = 0;
  logic        wt_valid;
  logic [15:0] wt_addr;
  logic [31:0] wt_data;

  vipt_lookup dut_i (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference state
  bit       m_tv [4];
  bit       m_trd [4], m_twr [4];
  bit [7:0] m_tvpn [4], m_tppn [4];
  bit        m_vld [64][2];
  bit [7:0]  m_tag [64][2];
  bit [31:0] m_dat [64][2];
  bit        m_rr  [64];

  task automatic chk(bit ok, string r, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic bit [31:0] fdat(bit [13:0] line);
    return 32'hC0DE0000 ^ {18'b0, line} ^ ({18'b0, line} << 17);
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic model_fill(bit [13:0] line, bit w, bit [31:0] d);
    bit [5:0] s = line[5:0];
    for (int k = 0; k < 2; k++)
      if (k == int'(w)) begin
        m_vld[s][k] = 1; m_tag[s][k] = line[13:6]; m_dat[s][k] = d;
      end else if (m_tag[s][k] == line[13:6]) m_vld[s][k] = 0;
  endtask

  task automatic do_fill(bit [13:0] line, bit w, bit [31:0] d);
    fill_valid = 1; fill_line = line; fill_way = w; fill_data = d;
    tick();
    fill_valid = 0;
    model_fill(line, w, d);
  endtask

  task automatic tlb_set(int i, bit [7:0] vpn, bit [7:0] ppn, bit rd, bit wr);
    tlb_wr_en = 1; tlb_wr_idx = 2'(i); tlb_wr_vpn = vpn; tlb_wr_ppn = ppn;
    tlb_wr_rd_ok = rd; tlb_wr_wr_ok = wr;
    tick();
    tlb_wr_en = 0;
    m_tv[i] = 1; m_tvpn[i] = vpn; m_tppn[i] = ppn; m_trd[i] = rd; m_twr[i] = wr;
  endtask

  task automatic do_req(bit wr, bit [15:0] va, bit [31:0] wd, string hr);
    bit e_tm, e_f, e_hit, e_ok, tr, tw;
    bit [7:0] ppn;
    bit [5:0] s;
    int hw;
    bit [13:0] line;
    req_valid = 1; req_write = wr; req_va = va; req_wdata = wd;
    tick();
    req_valid = 0;
    s = va[7:2];
    e_tm = 1; tr = 0; tw = 0; ppn = 0;
    for (int i = 3; i >= 0; i--)
      if (m_tv[i] && m_tvpn[i] == va[15:8]) begin
        e_tm = 0; ppn = m_tppn[i]; tr = m_trd[i]; tw = m_twr[i];
      end
    e_f = !e_tm && !(wr ? tw : tr);
    e_ok = !e_tm && !e_f;
    e_hit = 0; hw = 0;
    for (int k = 0; k < 2; k++)
      if (e_ok && m_vld[s][k] && m_tag[s][k] == ppn) begin e_hit = 1; hw = k; end
    line = {ppn, s};
    chk(rsp_valid == 1, "R1 response valid", 64'(rsp_valid), 1);
    chk(rsp_tlb_miss == e_tm, "R3 translation miss", 64'(rsp_tlb_miss), 64'(e_tm));
    chk(rsp_fault == e_f, "R4 permission fault", 64'(rsp_fault), 64'(e_f));
    chk(rsp_hit == e_hit, hr, 64'(rsp_hit), 64'(e_hit));
    chk(rsp_miss == (e_ok && !e_hit), "R1 miss outcome", 64'(rsp_miss), 64'(e_ok && !e_hit));
    if (e_hit && !wr)
      chk(rsp_rdata == m_dat[s][hw], {hr, " R5 data"}, 64'(rsp_rdata), 64'(m_dat[s][hw]));
    chk(refill_req == (e_ok && !e_hit && !wr), "R6 refill strobe",
        64'(refill_req), 64'(e_ok && !e_hit && !wr));
    chk(wt_valid == (e_ok && wr), "R8 write-through strobe", 64'(wt_valid), 64'(e_ok && wr));
    if (e_ok && wr) begin
      chk(wt_addr == {ppn, va[7:0]}, "R8 write-through address", 64'(wt_addr), 64'({ppn, va[7:0]}));
      chk(wt_data == wd, "R8 write-through data", 64'(wt_data), 64'(wd));
      if (e_hit) m_dat[s][hw] = wd;
    end
    if (e_ok && !e_hit && !wr) begin
      chk(refill_line == line, "R6 refill line", 64'(refill_line), 64'(line));
      chk(refill_way == m_rr[s], "R6 victim way", 64'(refill_way), 64'(m_rr[s]));
      m_rr[s] = !m_rr[s];
      fill_valid = 1; fill_line = line; fill_way = refill_way; fill_data = fdat(line);
      model_fill(line, refill_way, fdat(line));
    end
    tick();
    fill_valid = 0;
    chk(rsp_valid == 0, "R1 no response without request", 64'(rsp_valid), 0);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(rsp_valid == 0 && refill_req == 0 && wt_valid == 0, "R9 idle after reset",
        64'({rsp_valid, refill_req, wt_valid}), 0);

    do_req(0, 16'h0100, 0, "R3 hit before load");
    do_req(1, 16'h0104, 32'h1, "R3 hit before load");

    tlb_set(0, 8'h01, 8'h40, 1, 1);
    tlb_set(1, 8'h02, 8'h41, 1, 1);
    tlb_set(2, 8'h03, 8'h42, 1, 0);
    tlb_set(3, 8'h04, 8'h43, 0, 1);

    for (int s = 0; s < 64; s++) begin
      do_req(0, {8'h01, 6'(s), 2'b00}, 0, "R9 lines empty after reset");
      do_req(0, {8'h01, 6'(s), 2'b10}, 0, "R5 read hit");
    end
    for (int s = 0; s < 64; s++) begin
      do_req(0, {8'h02, 6'(s), 2'b01}, 0, "R6 second way miss");
      do_req(0, {8'h01, 6'(s), 2'b00}, 0, "R2 first way still hit");
      do_req(0, {8'h02, 6'(s), 2'b11}, 0, "R2 second way hit");
    end
    for (int s = 0; s < 64; s++) begin
      do_req(0, {8'h03, 6'(s), 2'b00}, 0, "R6 round-robin eviction");
      do_req(0, {8'h01, 6'(s), 2'b00}, 0, "R6 evicted line misses");
      do_req(0, {8'h03, 6'(s), 2'b00}, 0, "R5 read hit after refill");
    end
    for (int s = 0; s < 64; s++) begin
      do_req(1, {8'h01, 6'(s), 2'(s)}, 32'h1111 * s + 32'h7, "R8 write hit");
      do_req(0, {8'h01, 6'(s), 2'b00}, 0, "R8 written word read back");
    end
    do_req(1, {8'h02, 6'd5, 2'b00}, 32'hAB, "R8 write miss");
    do_req(0, {8'h02, 6'd5, 2'b00}, 0, "R8 write miss did not allocate");

    do_req(1, {8'h03, 6'd7, 2'b00}, 32'h5, "R4 write to read-only page");
    do_req(0, {8'h04, 6'd7, 2'b00}, 0, "R4 read of write-only page");
    do_req(1, {8'h04, 6'd7, 2'b00}, 32'h6, "R4 permitted write");

    tlb_set(3, 8'h05, 8'h40, 1, 1);
    for (int s = 0; s < 16; s++)
      do_req(0, {8'h05, 6'(s), 2'b00}, 0, "R2 alias page hit");
    do_req(1, {8'h05, 6'd3, 2'b00}, 32'hFACE, "R2 alias write");
    do_req(0, {8'h01, 6'd3, 2'b00}, 0, "R2 alias write seen");

    begin
      bit w;
      w = 0;
      for (int k = 0; k < 2; k++)
        if (m_vld[9][k] && m_tag[9][k] == 8'h40) w = !k[0];
      do_fill({8'h40, 6'd9}, w, 32'hDEAD0009);
      do_req(0, {8'h01, 6'd9, 2'b00}, 0, "R7 duplicate fill keeps one way");
      do_req(0, {8'h03, 6'd9, 2'b00}, 0, "R7 overwritten way");
    end

    summary();
  end

endmodule